// File: doc/BRIEF.md
# Two-Level Page Translator with Translation Cache

This block turns a 32-bit virtual address into a physical address for memory paged in 4 KiB units. Each request is first compared in parallel against an eight-entry translation cache. If the page is there, the physical address comes back one cycle after the request is accepted, with no memory traffic. If the page is not there, the block fetches two page-table entries from main memory through a word-read port: one from the outer table and one from the inner table it points to. It then loads the result into the cache and returns the translation.

Software controls the block through a table base register and a table-length input. The base register is written through a write strobe, and every write also empties the cache. A separate flush input empties the cache in one cycle. A request whose outer index is out of bounds, or that reaches an entry marked not present, gets a fault response instead of an address. The block handles only one request at a time.

Top module: `pt_xlate`

## Requirements
- R1: The address splits as outer index = bits 31:22, inner index = bits 21:12, offset = bits 11:0. The first table read uses address base + 4×outer index. Every table entry holds a 20-bit number in bits 31:12 and a present flag in bit 0. The second read uses address {outer entry bits 31:12, 12'h000} + 4×inner index. A successful response gives paddr = {inner entry bits 31:12, offset}.
- R2: A request whose page is in the cache gets resp_valid with resp_fault=0 in the cycle after acceptance, and no memory read is issued.
- R3: A request that misses the cache makes exactly two memory reads. The response comes in the cycle after the second read's data is returned, and the translation is stored so that a repeat of the same page hits.
- R4: A request whose outer index is greater than or equal to tbl_len gets resp_valid with resp_fault=1 in the cycle after acceptance, whether or not the page is cached, and no read is issued.
- R5: If an entry read from the table has bit 0 = 0, the response is a fault. A not-present outer entry ends the walk after one read. A fault is never stored in the cache, so repeating the same request walks the table again.
- R6: A pulse on flush, or a write to the base register, removes every cached translation from the next cycle on.
- R7: The cache holds 8 translations, and refills overwrite slots in round-robin order. The ninth distinct refill therefore evicts the oldest translation and keeps the other seven.
- R8: req_ready is low from the acceptance of a request that misses until its response. mem_req_valid and mem_req_addr stay steady until mem_rvalid is returned.
- R9: After reset, req_ready=1, resp_valid=0 and mem_req_valid=0, and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| base_we | input | 1 | Write strobe for the table base register (also flushes) |
| base_wdata | input | 32 | New outer-table base address |
| tbl_len | input | 11 | Number of legal outer entries |
| flush | input | 1 | Empty the translation cache |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_paddr | output | 32 | Physical address (zero on a fault) |
| resp_fault | output | 1 | Response is a translation fault |
| mem_req_valid | output | 1 | Table read request, held until answered |
| mem_req_addr | output | 32 | Word address of the table entry |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Table entry read from memory |

## Verification
The assertions assume that memory answers only while a read is pending and returns each answer as a single-cycle mem_rvalid pulse. They also assume that the base register and tbl_len do not change during a table walk, since the pending read address is derived from the base. The bench's memory model responds only to a pending request, after a fixed delay, and with a one-cycle pulse. The bench changes the base register and the table length only between requests, after the previous response has arrived.

// File: rtl/xlate_pkg.sv
// Shared widths and walk state encoding for the page translator.
// Assumes a 32-bit virtual address split into two 10-bit indices and a 12-bit offset.
package xlate_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 10;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PFN_W  = VPN_W;
    localparam int LEN_W  = IDX_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OUTER = 2'd1,
        ST_INNER = 2'd2
    } walk_state_t;
endpackage

// File: rtl/xlate_tlb.sv
// Fully associative translation cache with round-robin refill.
// Assumes no refill installs a page already present; flush wins over a refill in the same cycle.
module xlate_tlb #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lookup_vpn,
    output logic             hit,
    output logic [PFN_W-1:0] hit_pfn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             flush
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [PFN_W-1:0]   pfn_q [ENTRIES];
    logic [ENTRIES-1:0] match_vec;
    logic [PTR_W-1:0]   ptr_q;

    // Parallel compare of the looked-up page against every slot.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = valid_q[g] && (vpn_q[g] == lookup_vpn);
    end

    assign hit = |match_vec;

    // Select the frame of the matching slot (at most one matches).
    always_comb begin
        hit_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) hit_pfn = hit_pfn | pfn_q[i];
        end
    end

    // Slot valid flags, contents and round-robin pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                vpn_q[i] <= '0;
                pfn_q[i] <= '0;
            end
        end else if (flush) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[ptr_q] <= 1'b1;
            vpn_q[ptr_q]   <= fill_vpn;
            pfn_q[ptr_q]   <= fill_pfn;
            ptr_q          <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/xlate_walk.sv
// Request sequencer: bound check, cache-hit response and two-step table walk.
// Assumes memory answers a held read with a one-cycle rvalid pulse and that
// base and length stay fixed during a walk.
module xlate_walk
    import xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [VA_W-1:0]  base_addr,
    input  logic [LEN_W-1:0] tbl_len,
    input  logic             hit,
    input  logic [PFN_W-1:0] hit_pfn,
    output logic             resp_valid,
    output logic [VA_W-1:0]  resp_paddr,
    output logic             resp_fault,
    output logic             mem_req_valid,
    output logic [VA_W-1:0]  mem_req_addr,
    input  logic             mem_rvalid,
    input  logic [VA_W-1:0]  mem_rdata,
    output logic             fill_en,
    output logic [VPN_W-1:0] fill_vpn,
    output logic [PFN_W-1:0] fill_pfn
);
    walk_state_t     state_q;
    logic [VA_W-1:0] va_q;
    logic [VA_W-1:0] inner_base_q;
    logic            accept;
    logic            out_of_range;
    logic            entry_ok;
    logic            unused_rdata;

    assign req_ready    = (state_q == ST_IDLE);
    assign accept       = req_valid && req_ready;
    assign out_of_range = {1'b0, req_vaddr[VA_W-1 -: IDX_W]} >= tbl_len;
    assign entry_ok     = mem_rdata[0];
    assign unused_rdata = ^mem_rdata[OFF_W-1:1];

    // Table read request is held for the whole outer or inner step.
    assign mem_req_valid = (state_q != ST_IDLE);
    always_comb begin
        if (state_q == ST_OUTER)
            mem_req_addr = base_addr + {{(VA_W-IDX_W-2){1'b0}}, va_q[VA_W-1 -: IDX_W], 2'b00};
        else
            mem_req_addr = inner_base_q + {{(VA_W-IDX_W-2){1'b0}}, va_q[OFF_W +: IDX_W], 2'b00};
    end

    // Refill only on a present inner entry.
    assign fill_en  = (state_q == ST_INNER) && mem_rvalid && entry_ok;
    assign fill_vpn = va_q[VA_W-1:OFF_W];
    assign fill_pfn = mem_rdata[VA_W-1:OFF_W];

    // Walk state machine and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            va_q         <= '0;
            inner_base_q <= '0;
            resp_valid   <= 1'b0;
            resp_paddr   <= '0;
            resp_fault   <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (out_of_range) begin
                            resp_valid <= 1'b1;
                            resp_fault <= 1'b1;
                            resp_paddr <= '0;
                        end else if (hit) begin
                            resp_valid <= 1'b1;
                            resp_fault <= 1'b0;
                            resp_paddr <= {hit_pfn, req_vaddr[OFF_W-1:0]};
                        end else begin
                            va_q    <= req_vaddr;
                            state_q <= ST_OUTER;
                        end
                    end
                end
                ST_OUTER: begin
                    if (mem_rvalid) begin
                        if (!entry_ok) begin
                            resp_valid <= 1'b1;
                            resp_fault <= 1'b1;
                            resp_paddr <= '0;
                            state_q    <= ST_IDLE;
                        end else begin
                            inner_base_q <= {mem_rdata[VA_W-1:OFF_W], {OFF_W{1'b0}}};
                            state_q      <= ST_INNER;
                        end
                    end
                end
                ST_INNER: begin
                    if (mem_rvalid) begin
                        resp_valid <= 1'b1;
                        resp_fault <= !entry_ok;
                        resp_paddr <= entry_ok ? {mem_rdata[VA_W-1:OFF_W], va_q[OFF_W-1:0]} : '0;
                        state_q    <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pt_xlate.sv
// Top of the page translator: base register, translation cache and walk sequencer.
// Assumes one request in flight; a base write doubles as a cache flush.
module pt_xlate
    import xlate_pkg::*;
#(
    parameter int TLB_ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             base_we,
    input  logic [VA_W-1:0]  base_wdata,
    input  logic [LEN_W-1:0] tbl_len,
    input  logic             flush,
    output logic             resp_valid,
    output logic [VA_W-1:0]  resp_paddr,
    output logic             resp_fault,
    output logic             mem_req_valid,
    output logic [VA_W-1:0]  mem_req_addr,
    input  logic             mem_rvalid,
    input  logic [VA_W-1:0]  mem_rdata
);
    logic [VA_W-1:0]  base_q;
    logic             lookup_hit;
    logic [PFN_W-1:0] lookup_pfn;
    logic             fill_en;
    logic [VPN_W-1:0] fill_vpn;
    logic [PFN_W-1:0] fill_pfn;

    // Outer-table base register.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (base_we) base_q <= base_wdata;
    end

    xlate_tlb #(
        .ENTRIES (TLB_ENTRIES),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W)
    ) u_tlb (
        .clk        (clk),
        .rst_n      (rst_n),
        .lookup_vpn (req_vaddr[VA_W-1:OFF_W]),
        .hit        (lookup_hit),
        .hit_pfn    (lookup_pfn),
        .fill_en    (fill_en),
        .fill_vpn   (fill_vpn),
        .fill_pfn   (fill_pfn),
        .flush      (flush || base_we)
    );

    xlate_walk u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .base_addr     (base_q),
        .tbl_len       (tbl_len),
        .hit           (lookup_hit),
        .hit_pfn       (lookup_pfn),
        .resp_valid    (resp_valid),
        .resp_paddr    (resp_paddr),
        .resp_fault    (resp_fault),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata),
        .fill_en       (fill_en),
        .fill_vpn      (fill_vpn),
        .fill_pfn      (fill_pfn)
    );
endmodule

// File: rtl/pt_xlate_chk.sv
// Protocol and timing checks for pt_xlate, attached with bind.
// Assumes memory only answers a pending read and base/length are steady during a walk.
module pt_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic [10:0] tbl_len,
    input logic        flush,
    input logic        base_we,
    input logic        resp_valid,
    input logic [31:0] resp_paddr,
    input logic        resp_fault,
    input logic        mem_req_valid,
    input logic [31:0] mem_req_addr,
    input logic        mem_rvalid,
    input logic        lookup_hit
);
    logic        acc;
    logic        in_range;
    logic [11:0] off_q;
    logic        unused_chk;

    assign acc        = req_valid && req_ready;
    assign in_range   = {1'b0, req_vaddr[31:22]} < tbl_len;
    assign unused_chk = ^req_vaddr[21:12];

    // Offset of the most recently accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)   off_q <= '0;
        else if (acc) off_q <= req_vaddr[11:0];
    end

    assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault) |-> (resp_paddr[11:0] == off_q));

    assert_hit_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_range && lookup_hit) |=> (resp_valid && !resp_fault && !mem_req_valid));

    assert_len_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !in_range) |=> (resp_valid && resp_fault && !mem_req_valid));

    assert_flush_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush || base_we) |=> !lookup_hit);

    assert_busy_on_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_range && !lookup_hit) |=> (!req_ready && mem_req_valid));

    assert_read_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rvalid) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

bind pt_xlate pt_xlate_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .tbl_len       (tbl_len),
    .flush         (flush),
    .base_we       (base_we),
    .resp_valid    (resp_valid),
    .resp_paddr    (resp_paddr),
    .resp_fault    (resp_fault),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rvalid    (mem_rvalid),
    .lookup_hit    (lookup_hit)
);

// File: tb/pt_xlate_test.sv
// Directed bench for pt_xlate with a page-table memory model.
module pt_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic [10:0] tbl_len = 11'd8;
    logic        flush = 1'b0;
    logic        resp_valid;
    logic [31:0] resp_paddr;
    logic        resp_fault;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    localparam logic [31:0] TBASE = 32'h0010_0000;
    localparam logic [31:0] IBASE = 32'h0020_0000;

    int checks = 0;
    int failures = 0;
    int reads = 0;
    int lat_cnt = 0;
    bit done = 0;
    logic [31:0] pmem [logic [31:0]];
    logic [31:0] rd_log [4];

    always #2.5 clk = ~clk;

    pt_xlate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .base_we(base_we), .base_wdata(base_wdata),
        .tbl_len(tbl_len), .flush(flush), .resp_valid(resp_valid),
        .resp_paddr(resp_paddr), .resp_fault(resp_fault),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [19:0] frame_of(int oi, int ii);
        return {10'(oi) ^ 10'h2A5, 10'(ii) ^ 10'h0F0};
    endfunction

    function automatic logic [31:0] va(int oi, int ii, int off);
        return {10'(oi), 10'(ii), 12'(off)};
    endfunction

    // Memory model: answers a held read two cycles later with a one-cycle pulse.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rvalid) begin
                mem_rvalid = 1'b0;
            end else if (mem_req_valid) begin
                lat_cnt++;
                if (lat_cnt == 2) begin
                    lat_cnt = 0;
                    mem_rdata = pmem.exists(mem_req_addr) ? pmem[mem_req_addr] : 32'h0;
                    if (reads < 4) rd_log[reads] = mem_req_addr;
                    reads++;
                    mem_rvalid = 1'b1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one request from idle; report response, latency, reads and ready behaviour.
    task automatic xlate(input logic [31:0] a, output logic [31:0] pa, output bit flt,
                         output int lat, output int nrd, output bit busy_ok);
        @(negedge clk);
        reads = 0;
        req_vaddr = a;
        req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
        lat = 0;
        busy_ok = 1;
        forever begin
            @(negedge clk);
            lat++;
            if (resp_valid || lat > 40) break;
            if (req_ready) busy_ok = 0;
        end
        pa = resp_paddr;
        flt = resp_fault;
        nrd = reads;
    endtask

    task automatic expect_ok(input int oi, input int ii, input int off, input int exp_reads, input string tag);
        logic [31:0] pa; bit f; int lat; int n; bit b;
        xlate(va(oi, ii, off), pa, f, lat, n, b);
        check(!f, {tag, " fault"}, 32'(f), 0);
        check(pa == {frame_of(oi, ii), 12'(off)}, {tag, " paddr"}, pa, {frame_of(oi, ii), 12'(off)});
        check(n == exp_reads, {tag, " reads"}, n, exp_reads);
        check(lat == ((exp_reads == 0) ? 1 : 6), {tag, " latency"}, lat, (exp_reads == 0) ? 1 : 6);
        if (exp_reads != 0) check(b, {tag, " ready low in walk R8"}, 32'(b), 1);
    endtask

    task automatic expect_fault(input logic [31:0] a, input int exp_reads, input string tag);
        logic [31:0] pa; bit f; int lat; int n; bit b;
        xlate(a, pa, f, lat, n, b);
        check(f, {tag, " fault"}, 32'(f), 1);
        check(n == exp_reads, {tag, " reads"}, n, exp_reads);
    endtask

    task automatic test_reset();
        check(req_ready == 1'b1, "R9 ready", 32'(req_ready), 1);
        check(resp_valid == 1'b0, "R9 resp_valid", 32'(resp_valid), 0);
        check(mem_req_valid == 1'b0, "R9 mem_req_valid", 32'(mem_req_valid), 0);
    endtask

    task automatic test_walk();
        logic [31:0] pa; bit f; int lat; int n; bit b;
        xlate(va(1, 3, 12'h5A4), pa, f, lat, n, b);
        check(rd_log[0] == TBASE + 32'd4, "R1 outer read addr", rd_log[0], TBASE + 32'd4);
        check(rd_log[1] == IBASE + 32'h1000 + 32'd12, "R1 inner read addr", rd_log[1], IBASE + 32'h1000 + 32'd12);
        check(pa == {frame_of(1, 3), 12'h5A4}, "R1 paddr", pa, {frame_of(1, 3), 12'h5A4});
        check(n == 2 && lat == 6, "R3 two reads then respond", 32'(n * 16 + lat), 32'(2 * 16 + 6));
        expect_ok(1, 3, 12'h0FF, 0, "R2 hit same page");
        expect_ok(7, 9, 12'hFFF, 2, "R3 miss last legal outer");
        expect_ok(7, 9, 12'h000, 0, "R2 hit after refill");
    endtask

    task automatic test_length();
        expect_fault(va(8, 0, 0), 0, "R4 index equal to length");
        expect_fault(va(700, 1, 4), 0, "R4 far out of range");
        tbl_len = 11'd1;
        expect_fault(va(1, 3, 0), 0, "R4 cached page now out of range");
        tbl_len = 11'd8;
        expect_ok(1, 3, 12'h010, 0, "R4 back in range still cached");
    endtask

    task automatic test_invalid();
        expect_fault(va(4, 2, 0), 1, "R5 outer not present");
        expect_fault(va(4, 2, 0), 1, "R5 outer repeat no refill");
        expect_fault(va(1, 20, 8), 2, "R5 inner not present");
        expect_fault(va(1, 20, 8), 2, "R5 inner repeat no refill");
    endtask

    task automatic test_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        expect_ok(1, 3, 12'h020, 2, "R6 miss after flush");
        @(negedge clk); base_we = 1'b1; base_wdata = TBASE;
        @(negedge clk); base_we = 1'b0;
        expect_ok(1, 3, 12'h030, 2, "R6 miss after base write");
        expect_ok(1, 3, 12'h040, 0, "R6 refilled after base write");
    endtask

    task automatic test_round_robin();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        for (int i = 0; i < 8; i++) expect_ok(2, i, i * 16, 2, "R7 fill slot");
        for (int i = 0; i < 8; i++) expect_ok(2, i, 1, 0, "R7 all eight hit");
        expect_ok(2, 8, 0, 2, "R7 ninth page");
        for (int i = 1; i < 8; i++) expect_ok(2, i, 2, 0, "R7 survivors hit");
        expect_ok(2, 0, 3, 2, "R7 oldest evicted");
    endtask

    initial begin
        for (int o = 1; o < 8; o++) begin
            if (o != 4) pmem[TBASE + 32'(o * 4)] = (IBASE + 32'(o) * 32'h1000) | 32'h1;
        end
        for (int o = 1; o < 8; o++) begin
            for (int i = 0; i < 16; i++) begin
                pmem[IBASE + 32'(o) * 32'h1000 + 32'(i * 4)] = {frame_of(o, i), 11'h0, 1'b1};
            end
        end
        pmem[IBASE + 32'h1000 + 32'd80] = {frame_of(1, 20), 12'h0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        base_we = 1'b1; base_wdata = TBASE;
        @(negedge clk); base_we = 1'b0;
        test_walk();
        test_length();
        test_invalid();
        test_flush();
        test_round_robin();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule